// File: doc/BRIEF.md
# Node Combine Stage: Weight Multiply, ReLU and Unit-Norm Scaling

This block performs the combine step of one graph network layer for one node. A node's own feature vector from the previous layer and its aggregated neighbour vector arrive one element per transfer over a valid/ready stream. The self elements come first and the neighbour elements second, so the joined input has twice the feature width. Each joined element is broadcast to a row of multiply-accumulate cells, one cell per output element. Each cell multiplies the element by its own column of the layer weight matrix, which is held in an on-chip RAM written beforehand through a simple write port.

When the last input element has been accumulated, every sum is clamped to signed Q8.8 and passed through ReLU. The result is kept in a result buffer that stays valid for reuse until the next node begins. The block then forms the sum of squares, takes its integer square root with a sequential shift-and-subtract unit, and divides each buffered element by that root with a sequential restoring divider. The scaled vector leaves in Q1.14 over a valid/ready stream, element by element, together with the matching unscaled activation.

Top module: `node_combine`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Input transfer k (0-based) multiplies weight row k. Transfers 0..FEAT-1 are the self vector and transfers FEAT..2*FEAT-1 are the neighbour vector. Row k, column j of the weight RAM (written through w_row, w_col) feeds output element j.
- R3: Each product of two signed Q8.8 values is rounded to Q8.8 as (p + 128) >> 8 with an arithmetic shift, then clamped to [-32768, 32767]. The rounded products are summed without loss, and the sum is clamped to [-32768, 32767].
- R4: out_act for output j equals max(0, clamped sum j). It is never negative.
- R5: With S the sum over j of out_act squared, taken as integers, and r = floor(sqrt(S)), out_data for element j equals floor(out_act_j * 16384 / r). It never exceeds 16384.
- R6: When every activation is 0, each out_data is 0.
- R7: Outputs leave in order j = 0..OUTS-1, and out_last is 1 only on element OUTS-1.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_act and out_last hold their values.
- R9: in_ready is 0 from the acceptance of the final input element until the last output element is accepted, and is never 1 while out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_en | input | 1 | Weight RAM write strobe |
| w_row | input | $clog2(2*FEAT) | Weight row (joined input index) |
| w_col | input | $clog2(OUTS) | Weight column (output index) |
| w_data | input | 16 | Weight value, signed Q8.8 |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block accepts an input element |
| in_data | input | 16 | Input element, signed Q8.8 |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer accepts the output element |
| out_data | output | 16 | Normalized element, Q1.14 |
| out_act | output | 16 | Post-ReLU element, Q8.8 |
| out_last | output | 1 | Final element of the vector |

## Verification
A mixed-sign vector exercises ReLU clipping and a general norm. A vector with only a single nonzero self element shows that the row order is applied, and a vector with only a single nonzero neighbour element shows that this order differs between the two halves. Each of these two yields exactly 16384 on one lane. Full-scale inputs force product and sum saturation. An all-negative vector and an all-zero vector tell a real norm apart from the zero-norm path. A stalled consumer checks that the output holds and that the input stays closed.

// File: rtl/node_combine.sv
module node_combine #(
  parameter int FEAT = 4,
  parameter int OUTS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          w_en,
  input  logic [$clog2(2*FEAT)-1:0]     w_row,
  input  logic [$clog2(OUTS)-1:0]       w_col,
  input  logic [15:0]                   w_data,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [15:0]                   in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [15:0]                   out_data,
  output logic [15:0]                   out_act,
  output logic                          out_last
);
  localparam int DW    = 16;
  localparam int OFRAC = 14;
  localparam int NIN   = 2 * FEAT;
  localparam int KW    = $clog2(NIN);
  localparam int JW    = $clog2(OUTS);
  localparam int ACC_W = DW + KW + 1;
  localparam int SQ_W  = 2 * DW + 2 * JW + 2;
  localparam int RT_W  = SQ_W / 2;
  localparam int NUM_W = DW + OFRAC;

  typedef enum logic [2:0] {S_IN, S_MAC, S_SQ, S_RT, S_LD, S_DIV, S_OUT} st_t;
  st_t st;

  logic [DW-1:0]    w_mem [NIN][OUTS];
  logic [DW-1:0]    act   [OUTS];
  logic [ACC_W-1:0] acc   [OUTS];
  logic [DW-1:0]    x_r;
  logic [KW-1:0]    k, k_r;
  logic             mac_go;
  logic [JW-1:0]    idx;
  logic [SQ_W-1:0]  sq, rt_op, rt_res, rt_one;
  logic [RT_W-1:0]  root;
  logic [RT_W:0]    rem;
  logic [NUM_W-1:0] num;
  logic [5:0]       dcnt;

  function automatic logic [DW-1:0] prod_q(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [2*DW-1:0] p, r;
    p = $signed(a) * $signed(b);
    r = (p + 32'sd128) >>> 8;
    if (r > 32'sd32767) return 16'h7FFF;
    else if (r < -32'sd32768) return 16'h8000;
    else return r[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] relu_sat(input logic [ACC_W-1:0] s);
    if (s[ACC_W-1]) return '0;
    else if (s > ACC_W'(32767)) return 16'h7FFF;
    else return s[DW-1:0];
  endfunction

  wire accept = in_valid && in_ready;
  wire clr    = (st == S_MAC) && !mac_go;
  wire [SQ_W-1:0] sq_term = SQ_W'(act[idx]) * SQ_W'(act[idx]);
  wire [SQ_W-1:0] rt_try  = rt_res + rt_one;
  wire [RT_W:0]   rem_sh  = {rem[RT_W-1:0], num[NUM_W-1]};

  assign in_ready  = (st == S_IN);
  assign out_valid = (st == S_OUT);
  assign out_data  = num[DW-1:0];
  assign out_act   = act[idx];
  assign out_last  = (st == S_OUT) && (idx == JW'(OUTS - 1));

  always_ff @(posedge clk)
    if (w_en) w_mem[w_row][w_col] <= w_data;

  for (genvar g = 0; g < OUTS; g++) begin : g_pe
    logic [DW-1:0] pr;
    assign pr = prod_q(x_r, w_mem[k_r][g]);
    always_ff @(posedge clk)
      if (!rst_n || clr) acc[g] <= '0;
      else if (mac_go)   acc[g] <= acc[g] + {{(ACC_W-DW){pr[DW-1]}}, pr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IN;
      k      <= '0;
      k_r    <= '0;
      x_r    <= '0;
      mac_go <= 1'b0;
      idx    <= '0;
      sq     <= '0;
      rt_op  <= '0;
      rt_res <= '0;
      rt_one <= '0;
      root   <= '0;
      rem    <= '0;
      num    <= '0;
      dcnt   <= '0;
      for (int j = 0; j < OUTS; j++) act[j] <= '0;
    end else begin
      mac_go <= accept;
      if (accept) begin
        x_r <= in_data;
        k_r <= k;
        k   <= k + 1'b1;
        if (k == KW'(NIN - 1)) st <= S_MAC;
      end
      case (st)
        S_MAC: if (!mac_go) begin
          for (int j = 0; j < OUTS; j++) act[j] <= relu_sat(acc[j]);
          idx <= '0;
          sq  <= '0;
          st  <= S_SQ;
        end
        S_SQ: begin
          sq  <= sq + sq_term;
          idx <= idx + 1'b1;
          if (idx == JW'(OUTS - 1)) begin
            rt_op  <= sq + sq_term;
            rt_res <= '0;
            rt_one <= SQ_W'(1) << (SQ_W - 2);
            st     <= S_RT;
          end
        end
        S_RT: begin
          if (rt_one == '0) begin
            root <= rt_res[RT_W-1:0];
            idx  <= '0;
            st   <= S_LD;
          end else begin
            if (rt_op >= rt_try) begin
              rt_op  <= rt_op - rt_try;
              rt_res <= (rt_res >> 1) + rt_one;
            end else
              rt_res <= rt_res >> 1;
            rt_one <= rt_one >> 2;
          end
        end
        S_LD: begin
          rem  <= '0;
          dcnt <= '0;
          if (root == '0) begin
            num <= '0;
            st  <= S_OUT;
          end else begin
            num <= {act[idx], {OFRAC{1'b0}}};
            st  <= S_DIV;
          end
        end
        S_DIV: begin
          if (rem_sh >= {1'b0, root}) begin
            rem <= rem_sh - {1'b0, root};
            num <= {num[NUM_W-2:0], 1'b1};
          end else begin
            rem <= rem_sh;
            num <= {num[NUM_W-2:0], 1'b0};
          end
          dcnt <= dcnt + 1'b1;
          if (dcnt == 6'(NUM_W - 1)) st <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          if (idx == JW'(OUTS - 1)) begin
            k  <= '0;
            st <= S_IN;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_LD;
          end
        end
        default: ;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_act) && $stable(out_last));
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_relu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_act[15]);
  assert_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data <= 16'd16384);
  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_act == '0 |-> out_data == '0);
  assert_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: tb/sim_node_combine.sv
module sim_node_combine;
  localparam int FEAT = 4;
  localparam int OUTS = 4;
  localparam int NIN  = 2 * FEAT;
  localparam int NC   = 6;

  localparam logic [15:0] VEC [NC][NIN] = '{
    '{16'h0100, 16'h0080, 16'hFFC0, 16'h0200, 16'h00C0, 16'hFF00, 16'h0000, 16'h0080},
    '{16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
    '{16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0100, 16'h0000, 16'h0000, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic w_en = 0;
  logic [2:0] w_row = 0;
  logic [1:0] w_col = 0;
  logic [15:0] w_data = 0, in_data = 0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid, out_last;
  logic [15:0] out_data, out_act;
  int total = 0, bad = 0, cyc = 0;
  longint ea [OUTS];
  longint ey [OUTS];

  always #2.5 clk = ~clk;

  node_combine #(.FEAT(FEAT), .OUTS(OUTS)) u0 (
    .clk(clk), .rst_n(rst_n), .w_en(w_en), .w_row(w_row), .w_col(w_col), .w_data(w_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_act(out_act), .out_last(out_last));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic longint wt(int k, int j);
    return longint'(((k * 3 + j * 5) % 11) - 5) * 64;
  endfunction

  function automatic longint clamp16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, a, e);
    end
  endtask

  task automatic model(input int c);
    longint s, r, t;
    s = 0;
    for (int j = 0; j < OUTS; j++) begin
      longint acc = 0;
      for (int k = 0; k < NIN; k++)
        acc += clamp16((longint'($signed(VEC[c][k])) * wt(k, j) + 128) >>> 8);
      acc = clamp16(acc);
      ea[j] = (acc < 0) ? 0 : acc;
      s += ea[j] * ea[j];
    end
    r = 0;
    for (int b = 17; b >= 0; b--) begin
      t = r | (longint'(1) << b);
      if (t * t <= s) r = t;
    end
    for (int j = 0; j < OUTS; j++) ey[j] = (r == 0) ? 0 : (ea[j] * 16384) / r;
  endtask

  task automatic send_vec(input int c);
    for (int k = 0; k < NIN; k++) begin
      in_data = VEC[c][k];
      in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic recv_vec(input int c);
    out_ready = 1;
    for (int j = 0; j < OUTS; j++) begin
      while (!out_valid) @(negedge clk);
      chk(out_act == 16'(ea[j]), $sformatf("R4 R3 R2 act case%0d lane%0d", c, j), out_act, ea[j]);
      chk(out_data == 16'(ey[j]), $sformatf("R5 R6 norm case%0d lane%0d", c, j), out_data, ey[j]);
      chk(out_last == (j == OUTS - 1), $sformatf("R7 last case%0d lane%0d", c, j), out_last, j == OUTS - 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1 after release", {in_ready, out_valid}, 2);
    for (int k = 0; k < NIN; k++)
      for (int j = 0; j < OUTS; j++) begin
        w_en = 1; w_row = 3'(k); w_col = 2'(j); w_data = 16'(wt(k, j));
        @(negedge clk);
      end
    w_en = 0;

    for (int c = 0; c < NC; c++) begin
      model(c);
      send_vec(c);
      recv_vec(c);
    end

    // R8 and R9: stalled consumer
    model(0);
    out_ready = 0;
    send_vec(0);
    chk(in_ready == 0, "R9 closed after last input", in_ready, 0);
    while (!out_valid) @(negedge clk);
    begin
      logic [15:0] d0, a0;
      d0 = out_data; a0 = out_act;
      repeat (6) begin
        @(negedge clk);
        chk(out_valid && out_data == d0 && out_act == a0, "R8 hold", out_data, d0);
        chk(in_ready == 0, "R9 closed while stalled", in_ready, 0);
      end
    end
    recv_vec(0);
    chk(in_ready == 1, "R9 open after last output", in_ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule